// File: doc/BRIEF.md
# Two-Channel DMA Priority Arbiter

This block chooses which of two DMA channels owns the system bus for its next transfer. Each channel presents a request, a one-bit priority level, a stop flag (terminated or suspended, whether by software or by an interrupt) and a bus-release flag. A channel gives up the bus through the release flag when it inserts idle states during a destination-synchronized transfer. When the two priority bits differ, the high channel wins outright. When they are equal, the channels take turns.

The arbiter asks the bus interface for a cycle and waits until the interface accepts it. A refused request means the interface is serving something more urgent. While the accepted cycle runs, the arbiter drives a status bit marking a non-CPU bus master.

Arbitration takes place only at transfer boundaries. The owning channel keeps the grant across back-to-back transfers for as long as it still requests, is not stopped and has not released the bus. The block also turns each channel's transfer-count-zero event into an interrupt request when that channel's interrupt is enabled.

Top module: `dma_pair_arbiter`

## Requirements
- R1: After reset, grant, bus_req, ext_master and irq are all zero.
- R2: A channel is eligible when its request is high and its stop flag is low. A priority bit of 1 means high priority. With no grant held and both channels eligible, if their priority bits differ, the grant goes to the high channel. The grant appears one cycle after arbitration.
- R3: With equal priority bits (both 0 or both 1) and both channels eligible, the grant goes to the preferred channel. After reset, channel 0 is preferred. Each completed transfer makes the channel that did not run it the preferred one.
- R4: When a cycle ends (bus_done high while ext_master is high), an owner whose request is high and whose stop and release flags are low keeps the grant. This holds even if the other channel requests at higher priority.
- R5: An owner with its stop flag high at the end of a cycle loses the grant. A stopped channel is never newly granted.
- R6: An owner with its release flag high at the end of a cycle loses the grant for at least one cycle. If the other channel is not eligible, grant becomes zero, and the released channel may win again in the next arbitration.
- R7: bus_req is high only while a channel holds the grant, is still eligible and no cycle is running. A cycle starts on the clock edge where bus_req and bus_ack are both high. Otherwise the arbiter keeps waiting with the grant unchanged.
- R8: ext_master rises one cycle after the accepting edge and stays high, with grant unchanged, until the edge where bus_done is sampled high.
- R9: irq[i] pulses high for one cycle, one cycle after ch_tc[i] is sampled high while ch_irq_en[i] is high. When ch_irq_en[i] is low, irq[i] stays low.
- R10: grant is one-hot or zero, and a bit of grant never rises unless that channel requested in the previous cycle. If the owner's request drops before its cycle is accepted, bus_req falls at once and the grant is withdrawn on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req | input | 2 | Per-channel transfer request |
| ch_hi | input | 2 | Per-channel priority level, 1 = high |
| ch_stop | input | 2 | Per-channel terminated or suspended flag |
| ch_release | input | 2 | Per-channel bus release at end of the current cycle |
| ch_tc | input | 2 | Per-channel transfer-count-zero event |
| ch_irq_en | input | 2 | Per-channel interrupt enable |
| bus_ack | input | 1 | Bus interface accepts the requested cycle |
| bus_done | input | 1 | Running bus cycle completes |
| grant | output | 2 | One-hot channel grant, zero when idle |
| bus_req | output | 1 | Cycle request to the bus interface |
| ext_master | output | 1 | Status bit: a non-CPU master runs the bus cycle |
| irq | output | 2 | Per-channel interrupt request pulse |

## Verification
A corrupted rotation pointer stays invisible until both channels request at equal priority from idle. It then shows up as the wrong grant bit one cycle after arbitration. The directed tests therefore put a single-channel transfer in front of every rotation check. A controller state that is out of step with the bus shows up within a cycle in one of three ways: bus_req and ext_master are high together, ext_master does not follow an accepted request, or the grant changes while ext_master is high. A wrong hold decision appears as a grant change on the edge right after bus_done.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_WAIT = 2'd1,
      ARB_RUN  = 2'd2
   } arb_state_e;

   function automatic logic [1:0] idx_to_mask(input logic idx);
      logic [1:0] m;
      m = 2'b00;
      m[idx] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
   parameter int CH_NUM = 2,
   localparam int IDX_W = (CH_NUM > 1) ? $clog2(CH_NUM) : 1
) (
   input  logic [CH_NUM-1:0] elig,
   input  logic [CH_NUM-1:0] lvl,
   input  logic [IDX_W-1:0]  favor,
   output logic [IDX_W-1:0]  win,
   output logic              win_vld
);

   generate
      if (CH_NUM != 2) begin : g_bad_count
         $error("dma_arb_pick supports exactly two channels");
      end
   endgenerate

   logic split_lvl;
   assign split_lvl = lvl[0] ^ lvl[1];

   always_comb begin
      win     = favor;
      win_vld = |elig;
      unique case (elig)
         2'b01:   win = 1'b0;
         2'b10:   win = 1'b1;
         2'b11: begin
            if (split_lvl) win = lvl[1];
            else           win = favor;
         end
         default: win = favor;
      endcase
   end

endmodule

// File: rtl/dma_arb_rotor.sv
module dma_arb_rotor #(
   parameter int CH_NUM      = 2,
   parameter int RESET_FAVOR = 0,
   localparam int IDX_W = (CH_NUM > 1) ? $clog2(CH_NUM) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic [IDX_W-1:0] last_owner,
   output logic [IDX_W-1:0] favor
);

   generate
      if (RESET_FAVOR < 0 || RESET_FAVOR >= CH_NUM) begin : g_bad_favor
         $error("RESET_FAVOR must name an existing channel");
      end
   endgenerate

   localparam logic [IDX_W-1:0] FAVOR_INIT = IDX_W'(RESET_FAVOR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       favor <= FAVOR_INIT;
      else if (advance) favor <= ~last_owner;
   end

endmodule

// File: rtl/dma_arb_irq.sv
module dma_arb_irq #(
   parameter int CH_NUM  = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_NUM-1:0] tc,
   input  logic [CH_NUM-1:0] en,
   output logic [CH_NUM-1:0] irq
);

   for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq[c] <= 1'b0;
            else        irq[c] <= tc[c] & en[c];
         end
      end else begin : g_comb
         assign irq[c] = tc[c] & en[c];
      end
   end

endmodule

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter #(
   parameter int CH_NUM      = 2,
   parameter int RESET_FAVOR = 0,
   parameter bit IRQ_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_NUM-1:0] ch_req,
   input  logic [CH_NUM-1:0] ch_hi,
   input  logic [CH_NUM-1:0] ch_stop,
   input  logic [CH_NUM-1:0] ch_release,
   input  logic [CH_NUM-1:0] ch_tc,
   input  logic [CH_NUM-1:0] ch_irq_en,
   input  logic              bus_ack,
   input  logic              bus_done,
   output logic [CH_NUM-1:0] grant,
   output logic              bus_req,
   output logic              ext_master,
   output logic [CH_NUM-1:0] irq
);
   import dma_arb_pkg::*;

   localparam int IDX_W = (CH_NUM > 1) ? $clog2(CH_NUM) : 1;

   generate
      if (CH_NUM != 2) begin : g_bad_count
         $error("dma_pair_arbiter is built for exactly two channels");
      end
   endgenerate

   arb_state_e        st_q, st_d;
   logic [IDX_W-1:0]  own_q, own_d;
   logic [IDX_W-1:0]  favor;
   logic [CH_NUM-1:0] elig, own_mask, alt_elig;
   logic              own_ok, own_keep, advance;
   logic [IDX_W-1:0]  a_win, b_win;
   logic              a_vld, b_vld;

   assign elig     = ch_req & ~ch_stop;
   assign own_mask = idx_to_mask(own_q);
   assign own_ok   = elig[own_q];
   assign own_keep = own_ok & ~ch_release[own_q];
   assign alt_elig = elig & ~own_mask;

   dma_arb_pick #(.CH_NUM(CH_NUM)) pick_open_i (
      .elig    (elig),
      .lvl     (ch_hi),
      .favor   (favor),
      .win     (a_win),
      .win_vld (a_vld)
   );

   dma_arb_pick #(.CH_NUM(CH_NUM)) pick_hand_i (
      .elig    (alt_elig),
      .lvl     (ch_hi),
      .favor   (favor),
      .win     (b_win),
      .win_vld (b_vld)
   );

   dma_arb_rotor #(.CH_NUM(CH_NUM), .RESET_FAVOR(RESET_FAVOR)) rotor_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance    (advance),
      .last_owner (own_q),
      .favor      (favor)
   );

   dma_arb_irq #(.CH_NUM(CH_NUM), .IRQ_REG(IRQ_REG)) irq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tc    (ch_tc),
      .en    (ch_irq_en),
      .irq   (irq)
   );

   always_comb begin
      st_d    = st_q;
      own_d   = own_q;
      advance = 1'b0;
      unique case (st_q)
         ARB_IDLE: begin
            if (a_vld) begin
               st_d  = ARB_WAIT;
               own_d = a_win;
            end
         end
         ARB_WAIT: begin
            if (!own_ok) begin
               if (a_vld) own_d = a_win;
               else       st_d  = ARB_IDLE;
            end else if (bus_ack) begin
               st_d = ARB_RUN;
            end
         end
         ARB_RUN: begin
            if (bus_done) begin
               advance = 1'b1;
               if (own_keep) begin
                  st_d = ARB_WAIT;
               end else if (b_vld) begin
                  st_d  = ARB_WAIT;
                  own_d = b_win;
               end else begin
                  st_d = ARB_IDLE;
               end
            end
         end
         default: st_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ARB_IDLE;
         own_q <= '0;
      end else begin
         st_q  <= st_d;
         own_q <= own_d;
      end
   end

   assign grant      = (st_q == ARB_IDLE) ? '0 : own_mask;
   assign bus_req    = (st_q == ARB_WAIT) & own_ok;
   assign ext_master = (st_q == ARB_RUN);

endmodule

// File: rtl/dma_pair_arbiter_chk.sv
module dma_pair_arbiter_chk #(
   parameter int CH_NUM  = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CH_NUM-1:0] ch_req,
   input logic [CH_NUM-1:0] ch_hi,
   input logic [CH_NUM-1:0] ch_stop,
   input logic [CH_NUM-1:0] ch_release,
   input logic [CH_NUM-1:0] ch_tc,
   input logic [CH_NUM-1:0] ch_irq_en,
   input logic              bus_ack,
   input logic              bus_done,
   input logic [CH_NUM-1:0] grant,
   input logic              bus_req,
   input logic              ext_master,
   input logic [CH_NUM-1:0] irq
);

   // R10
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R10
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant & ~$past(grant))) |-> (|(grant & $past(ch_req))));

   // R2
   fixed_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0 && !ext_master && (&(ch_req & ~ch_stop)) && (ch_hi[0] != ch_hi[1]))
      |=> (grant == $past(ch_hi)));

   // R4
   hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_master && bus_done && (|(grant & ch_req & ~ch_stop & ~ch_release)))
      |=> (grant == $past(grant)));

   // R5
   stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_master && bus_done && (|(grant & ch_stop)))
      |=> !(|(grant & $past(grant))));

   // R6
   release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_master && bus_done && (|(grant & ch_release)))
      |=> !(|(grant & $past(grant))));

   // R7
   req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (!ext_master && (|(grant & ch_req & ~ch_stop))));

   // R7
   start_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack) |=> ext_master);

   // R8
   run_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_master && !bus_done) |=> (ext_master && $stable(grant)));

   // R8
   run_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_master |-> $onehot(grant));

   generate
      if (IRQ_REG) begin : g_irq_reg
         // R9
         irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq == $past(ch_tc & ch_irq_en));
      end else begin : g_irq_comb
         // R9
         irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (ch_tc & ch_irq_en));
      end
   endgenerate

endmodule

bind dma_pair_arbiter dma_pair_arbiter_chk #(.CH_NUM(CH_NUM), .IRQ_REG(IRQ_REG)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ch_req     (ch_req),
   .ch_hi      (ch_hi),
   .ch_stop    (ch_stop),
   .ch_release (ch_release),
   .ch_tc      (ch_tc),
   .ch_irq_en  (ch_irq_en),
   .bus_ack    (bus_ack),
   .bus_done   (bus_done),
   .grant      (grant),
   .bus_req    (bus_req),
   .ext_master (ext_master),
   .irq        (irq)
);

// File: tb/dma_pair_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_pair_arbiter_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] req = '0, hi = '0, stop = '0, rel = '0, tc = '0, ien = '0;
   logic       ack = 1'b0, done = 1'b0;
   logic [1:0] grant, irq;
   logic       bus_req, ext_master;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dma_pair_arbiter dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ch_req     (req),
      .ch_hi      (hi),
      .ch_stop    (stop),
      .ch_release (rel),
      .ch_tc      (tc),
      .ch_irq_en  (ien),
      .bus_ack    (ack),
      .bus_done   (done),
      .grant      (grant),
      .bus_req    (bus_req),
      .ext_master (ext_master),
      .irq        (irq)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req = '0; hi = '0; stop = '0; rel = '0; tc = '0; ien = '0;
      ack = 1'b0; done = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 grant", {2'b0, grant}, 4'h0);
      check("R1 bus_req", {3'b0, bus_req}, 4'h0);
      check("R1 ext_master", {3'b0, ext_master}, 4'h0);
      check("R1 irq", {2'b0, irq}, 4'h0);
   endtask

   task automatic t_fixed();
      do_reset();
      hi = 2'b01; req = 2'b11;
      tick();
      check("R2 ch0 high", {2'b0, grant}, 4'h1);
      do_reset();
      hi = 2'b10; req = 2'b11;
      tick();
      check("R2 ch1 high", {2'b0, grant}, 4'h2);
   endtask

   task automatic t_rotate();
      do_reset();
      req = 2'b01;
      tick();
      check("R3 solo ch0", {2'b0, grant}, 4'h1);
      ack = 1'b1;
      tick();
      ack = 1'b0; done = 1'b1; req = 2'b00;
      tick();
      check("R3 idle after solo", {2'b0, grant}, 4'h0);
      done = 1'b0; req = 2'b11;
      tick();
      check("R3 rotated to ch1 (both low)", {2'b0, grant}, 4'h2);
      ack = 1'b1;
      tick();
      ack = 1'b0; done = 1'b1; req = 2'b00;
      tick();
      done = 1'b0; hi = 2'b11; req = 2'b11;
      tick();
      check("R3 rotated to ch0 (both high)", {2'b0, grant}, 4'h1);
   endtask

   task automatic t_hold();
      do_reset();
      hi = 2'b10; req = 2'b01;
      tick();
      check("R4 first grant", {2'b0, grant}, 4'h1);
      ack = 1'b1; req = 2'b11;
      tick();
      check("R8 ext_master running", {3'b0, ext_master}, 4'h1);
      ack = 1'b0; done = 1'b1;
      tick();
      check("R4 owner kept vs high ch1", {2'b0, grant}, 4'h1);
      check("R7 bus_req for next transfer", {3'b0, bus_req}, 4'h1);
      done = 1'b0; ack = 1'b1;
      tick();
      ack = 1'b0; done = 1'b1; req = 2'b10;
      tick();
      check("R4 handover after request drop", {2'b0, grant}, 4'h2);
      done = 1'b0;
   endtask

   task automatic t_stop();
      do_reset();
      req = 2'b11;
      tick();
      check("R5 initial ch0", {2'b0, grant}, 4'h1);
      ack = 1'b1;
      tick();
      ack = 1'b0; done = 1'b1; stop = 2'b01;
      tick();
      check("R5 stopped owner loses", {2'b0, grant}, 4'h2);
      done = 1'b0;
      do_reset();
      stop = 2'b01; req = 2'b01;
      repeat (2) tick();
      check("R5 stopped channel not granted", {2'b0, grant}, 4'h0);
   endtask

   task automatic t_release();
      do_reset();
      req = 2'b01;
      tick();
      ack = 1'b1;
      tick();
      ack = 1'b0; done = 1'b1; rel = 2'b01;
      tick();
      check("R6 released grant zero", {2'b0, grant}, 4'h0);
      check("R6 released bus_req low", {3'b0, bus_req}, 4'h0);
      rel = 2'b00; done = 1'b0;
      tick();
      check("R6 regrant after release", {2'b0, grant}, 4'h1);
   endtask

   task automatic t_biu_wait();
      do_reset();
      req = 2'b10;
      tick();
      for (int k = 0; k < 4; k++) begin
         check("R7 waiting bus_req", {3'b0, bus_req}, 4'h1);
         check("R7 waiting ext_master", {3'b0, ext_master}, 4'h0);
         check("R7 waiting grant", {2'b0, grant}, 4'h2);
         tick();
      end
      ack = 1'b1;
      tick();
      ack = 1'b0;
      check("R8 ext_master after ack", {3'b0, ext_master}, 4'h1);
      check("R8 bus_req drops in cycle", {3'b0, bus_req}, 4'h0);
      tick();
      check("R8 ext_master held", {3'b0, ext_master}, 4'h1);
      check("R8 grant held", {2'b0, grant}, 4'h2);
      done = 1'b1; req = 2'b00;
      tick();
      done = 1'b0;
      check("R8 ext_master ends", {3'b0, ext_master}, 4'h0);
   endtask

   task automatic t_drop_wait();
      do_reset();
      req = 2'b01;
      tick();
      check("R10 granted", {2'b0, grant}, 4'h1);
      req = 2'b00; ack = 1'b1;
      #1;
      check("R10 bus_req falls at once", {3'b0, bus_req}, 4'h0);
      tick();
      ack = 1'b0;
      check("R10 grant withdrawn", {2'b0, grant}, 4'h0);
      check("R10 no cycle started", {3'b0, ext_master}, 4'h0);
   endtask

   task automatic t_irq();
      do_reset();
      ien = 2'b01; tc = 2'b11;
      tick();
      tc = 2'b00;
      check("R9 irq enabled only", {2'b0, irq}, 4'h1);
      tick();
      check("R9 irq pulse ends", {2'b0, irq}, 4'h0);
   endtask

   initial begin
      t_reset();
      t_fixed();
      t_rotate();
      t_hold();
      t_stop();
      t_release();
      t_biu_wait();
      t_drop_wait();
      t_irq();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule